// File: doc/BRIEF.md
# Transmit Slot Reader

The block streams outgoing Ethernet frames out of a bank of transmit buffer slots that software has already filled. Software pushes a command made of a slot number and a byte count. The command waits in a small queue. A read sequencer takes the oldest command, fetches the slot's bytes through a memory read port that has one cycle of latency, and sends them on a byte stream with valid/ready handshake and an end-of-frame marker. Backpressure from the stream stalls the sequencer without losing or repeating bytes.

After the last byte of a frame is accepted, the sequencer spends exactly one cycle in its finishing state and, in that cycle, produces one completion record. The record holds the slot number. When the timestamp option is on, it also holds the value of a free-running time input, sampled in the cycle the frame's first byte was accepted. With the option on, records queue in a status FIFO. A level event line stays high while any record is waiting, and software removes the head record with a one-cycle pop strobe. With the option off there is no status FIFO: the event line gives one single-cycle pulse per completed frame, and the record fields are valid during that pulse.

The slot count is a parameter of its own, and two slots used alternately are enough for transmit. The slot memory address is the slot number times the slot size plus the byte offset.

Top module: `tx_slot_reader`

## Requirements
- R1: Frame byte i (counting from 0) equals the memory byte at address slot*SLOT_BYTES + i. Bytes come out in increasing i, and no output is valid while the sequencer is idle.
- R2: `out_last_o` is high on the final byte of each frame and on no other byte.
- R3: A requested length of 0, or one greater than SLOT_BYTES, is sent as SLOT_BYTES bytes and still yields exactly one completion record.
- R4: While `out_valid_o` is high and `out_ready_i` is low, the next cycle keeps `out_valid_o` high with `out_data_o` and `out_last_o` unchanged.
- R5: Each frame produces exactly one completion record. Records appear in command order and carry the frame's slot number. The finishing state lasts one cycle and is followed by idle.
- R6: With TS_EN=1, a record's `stat_ts_o` equals the `ts_i` value in the cycle the frame's first byte was accepted (valid and ready both high).
- R7: With TS_EN=1, `event_o` is high exactly while at least one record is waiting. A `stat_pop_i` pulse removes the head record.
- R8: With TS_EN=0, `event_o` is a one-cycle pulse per completed frame, and `stat_slot_o` gives that frame's slot during the pulse.
- R9: The command queue holds CMD_DEPTH (default 4) commands behind the frame in progress. `cmd_ready_o` is low when the queue is full, and a command offered while it is low is dropped.
- R10: During reset `out_valid_o` and `event_o` are low and `cmd_ready_o` is high.
- R11: With TS_EN=1, no new frame starts while the status FIFO is full. The pending frame starts after a pop, so no record is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command queue has room |
| cmd_slot_i | input | SLOT_W | Slot number of the frame |
| cmd_len_i | input | CMD_LEN_W | Requested frame length in bytes |
| mem_rd_en_o | output | 1 | Slot memory read strobe |
| mem_addr_o | output | ADDR_W | Slot memory byte address |
| mem_rd_data_i | input | 8 | Read data, one cycle after the strobe |
| out_valid_o | output | 1 | Stream byte valid |
| out_ready_i | input | 1 | Stream sink accepts a byte |
| out_data_o | output | 8 | Stream byte |
| out_last_o | output | 1 | Final byte of the frame |
| ts_i | input | TS_W | Free-running timestamp |
| event_o | output | 1 | Completion level (TS_EN=1) or pulse (TS_EN=0) |
| stat_pop_i | input | 1 | Remove the head completion record |
| stat_slot_o | output | SLOT_W | Slot number of the head record |
| stat_ts_o | output | TS_W | Timestamp of the head record |

## Verification
Corner cases covered by the bench:
- **Lengths.** Frames of length zero and of a size above the slot size must come out as full slots. A design without clamping would send nothing, or would read past the slot and never reach the final byte.
- **Backpressure.** A scrambled ready pattern checks that a stalled byte holds steady. If read data arriving during a stall were dropped, or written over the byte on display, a byte would be missing or duplicated.
- **Full queues.** The bench fills the command queue and checks that an extra command is refused. It fills the status FIFO and checks that the next frame waits until a pop; a design that started anyway would lose a record.
- **Event behaviour.** Records must be pushed once per frame, not repeatedly while idle. The level event must stay high across several waiting records. In the build without timestamps, the event must stay a single-cycle pulse.

// File: rtl/tx_slot_pkg.sv
package tx_slot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_END  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/tx_sync_fifo.sv
module tx_sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem_q [DEPTH];
  logic [AW:0]  wp_q, rp_q;
  logic         do_push, do_pop;

  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign empty_o = (wp_q == rp_q);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rp_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q[AW-1:0]] <= din_i;
  end
endmodule

// File: rtl/tx_read_engine.sv
module tx_read_engine
  import tx_slot_pkg::*;
#(
  parameter int NUM_SLOTS  = 2,
  parameter int SLOT_BYTES = 64,
  parameter int CMD_LEN_W  = 16,
  parameter int TS_W       = 32,
  parameter int SLOT_W     = 1,
  parameter int ADDR_W     = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_avail_i,
  input  logic [SLOT_W-1:0]    cmd_slot_i,
  input  logic [CMD_LEN_W-1:0] cmd_len_i,
  input  logic                 stat_room_i,
  output logic                 cmd_take_o,
  output logic                 mem_rd_en_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  input  logic [7:0]           mem_rd_data_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [7:0]           out_data_o,
  output logic                 out_last_o,
  input  logic [TS_W-1:0]      ts_i,
  output logic                 done_o,
  output logic [SLOT_W-1:0]    done_slot_o,
  output logic [TS_W-1:0]      done_ts_o,
  output rd_state_e            state_o
);
  localparam int LEN_W = $clog2(SLOT_BYTES + 1);

  rd_state_e         state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [LEN_W-1:0]  len_q, rd_cnt_q, len_eff;
  logic              pend_q, pend_last_q, first_q;
  logic              ov_q, ol_q, hv_q, hl_q;
  logic [7:0]        od_q, hd_q;
  logic [TS_W-1:0]   ts_q;

  logic              fire, slot_free, issue, start;
  logic              ov_n, ol_n, hv_n, hl_n;
  logic [7:0]        od_n, hd_n;

  // oversize or zero length sends a whole slot
  always_comb begin
    if (cmd_len_i == '0 || cmd_len_i > CMD_LEN_W'(SLOT_BYTES)) len_eff = LEN_W'(SLOT_BYTES);
    else                                                       len_eff = LEN_W'(cmd_len_i);
  end

  assign start      = (state_q == ST_IDLE) && cmd_avail_i && stat_room_i;
  assign cmd_take_o = start;
  assign fire       = ov_q && out_ready_i;
  assign slot_free  = !ov_q || fire;

  // output register plus one hold entry absorbs read data landing during a stall
  always_comb begin
    ov_n = ov_q; od_n = od_q; ol_n = ol_q;
    hv_n = hv_q; hd_n = hd_q; hl_n = hl_q;
    if (slot_free) begin
      if (hv_q) begin
        ov_n = 1'b1;   od_n = hd_q;          ol_n = hl_q;
        hv_n = pend_q; hd_n = mem_rd_data_i; hl_n = pend_last_q;
      end else begin
        ov_n = pend_q; od_n = mem_rd_data_i; ol_n = pend_last_q;
        hv_n = 1'b0;
      end
    end else if (pend_q) begin
      hv_n = 1'b1; hd_n = mem_rd_data_i; hl_n = pend_last_q;
    end
  end

  assign issue       = (state_q == ST_READ) && (rd_cnt_q != len_q) && !(ov_n && hv_n);
  assign mem_rd_en_o = issue;
  assign mem_addr_o  = ADDR_W'(slot_q) * ADDR_W'(SLOT_BYTES) + ADDR_W'(rd_cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      slot_q      <= '0;
      len_q       <= '0;
      rd_cnt_q    <= '0;
      pend_q      <= 1'b0;
      pend_last_q <= 1'b0;
      first_q     <= 1'b0;
      ov_q        <= 1'b0;
      od_q        <= '0;
      ol_q        <= 1'b0;
      hv_q        <= 1'b0;
      hd_q        <= '0;
      hl_q        <= 1'b0;
      ts_q        <= '0;
    end else begin
      ov_q <= ov_n; od_q <= od_n; ol_q <= ol_n;
      hv_q <= hv_n; hd_q <= hd_n; hl_q <= hl_n;
      pend_q      <= issue;
      pend_last_q <= issue && (rd_cnt_q == len_q - LEN_W'(1));
      if (issue) rd_cnt_q <= rd_cnt_q + LEN_W'(1);
      if (fire && first_q) begin
        ts_q    <= ts_i;
        first_q <= 1'b0;
      end
      unique case (state_q)
        ST_IDLE: if (start) begin
          slot_q   <= cmd_slot_i;
          len_q    <= len_eff;
          rd_cnt_q <= '0;
          first_q  <= 1'b1;
          state_q  <= ST_READ;
        end
        ST_READ: if (fire && ol_q) state_q <= ST_END;
        ST_END:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid_o = ov_q;
  assign out_data_o  = od_q;
  assign out_last_o  = ol_q;
  assign done_o      = (state_q == ST_END);
  assign done_slot_o = slot_q;
  assign done_ts_o   = ts_q;
  assign state_o     = state_q;
endmodule

// File: rtl/tx_slot_reader.sv
module tx_slot_reader
  import tx_slot_pkg::*;
#(
  parameter int NUM_SLOTS  = 2,
  parameter int SLOT_BYTES = 64,
  parameter int CMD_LEN_W  = 16,
  parameter int TS_EN      = 1,
  parameter int TS_W       = 32,
  parameter int CMD_DEPTH  = 4,
  parameter int STAT_DEPTH = 4,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int ADDR_W    = $clog2(NUM_SLOTS * SLOT_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic [SLOT_W-1:0]    cmd_slot_i,
  input  logic [CMD_LEN_W-1:0] cmd_len_i,
  output logic                 mem_rd_en_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  input  logic [7:0]           mem_rd_data_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [7:0]           out_data_o,
  output logic                 out_last_o,
  input  logic [TS_W-1:0]      ts_i,
  output logic                 event_o,
  input  logic                 stat_pop_i,
  output logic [SLOT_W-1:0]    stat_slot_o,
  output logic [TS_W-1:0]      stat_ts_o
);
  localparam int CMD_W = SLOT_W + CMD_LEN_W;

  logic [CMD_W-1:0]  cmd_head;
  logic              cmd_full, cmd_empty, cmd_take;
  logic              stat_room, done;
  logic [SLOT_W-1:0] done_slot;
  logic [TS_W-1:0]   done_ts;
  rd_state_e         fsm_state;

  tx_sync_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) i_cmd_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (cmd_valid_i),
    .din_i   ({cmd_slot_i, cmd_len_i}),
    .pop_i   (cmd_take),
    .dout_o  (cmd_head),
    .full_o  (cmd_full),
    .empty_o (cmd_empty)
  );
  assign cmd_ready_o = !cmd_full;

  tx_read_engine #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES), .CMD_LEN_W(CMD_LEN_W),
    .TS_W(TS_W), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)
  ) i_engine (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_avail_i   (!cmd_empty),
    .cmd_slot_i    (cmd_head[CMD_W-1:CMD_LEN_W]),
    .cmd_len_i     (cmd_head[CMD_LEN_W-1:0]),
    .stat_room_i   (stat_room),
    .cmd_take_o    (cmd_take),
    .mem_rd_en_o   (mem_rd_en_o),
    .mem_addr_o    (mem_addr_o),
    .mem_rd_data_i (mem_rd_data_i),
    .out_valid_o   (out_valid_o),
    .out_ready_i   (out_ready_i),
    .out_data_o    (out_data_o),
    .out_last_o    (out_last_o),
    .ts_i          (ts_i),
    .done_o        (done),
    .done_slot_o   (done_slot),
    .done_ts_o     (done_ts),
    .state_o       (fsm_state)
  );

  if (TS_EN != 0) begin : g_stat_fifo
    logic [SLOT_W+TS_W-1:0] head;
    logic                   s_full, s_empty;
    tx_sync_fifo #(.W(SLOT_W + TS_W), .DEPTH(STAT_DEPTH)) i_stat_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (done),
      .din_i   ({done_slot, done_ts}),
      .pop_i   (stat_pop_i),
      .dout_o  (head),
      .full_o  (s_full),
      .empty_o (s_empty)
    );
    assign stat_room   = !s_full;
    assign event_o     = !s_empty;
    assign stat_slot_o = head[SLOT_W+TS_W-1:TS_W];
    assign stat_ts_o   = head[TS_W-1:0];
  end else begin : g_stat_pulse
    assign stat_room   = 1'b1;
    assign event_o     = done;
    assign stat_slot_o = done_slot;
    assign stat_ts_o   = done_ts;
  end
endmodule

// File: rtl/tx_slot_reader_chk.sv
module tx_slot_reader_chk
  import tx_slot_pkg::*;
#(
  parameter int TS_EN = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input rd_state_e  state_i,
  input logic       mem_rd_en_i,
  input logic       out_valid_i,
  input logic       out_ready_i,
  input logic [7:0] out_data_i,
  input logic       out_last_i,
  input logic       event_i,
  input logic       stat_pop_i
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IDLE |-> !out_valid_i && !mem_rd_en_i);

  // R2
  last_ends_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && out_ready_i && out_last_i |=> state_i == ST_END);

  // R4
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_i && !out_ready_i |=> out_valid_i && $stable(out_data_i) && $stable(out_last_i));

  // R5
  end_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_END |=> state_i == ST_IDLE);

  // R7
  event_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TS_EN != 0) && event_i && !stat_pop_i |=> event_i);

  // R8
  event_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TS_EN == 0) && event_i |=> !event_i);
endmodule

bind tx_slot_reader tx_slot_reader_chk #(.TS_EN(TS_EN)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_i     (fsm_state),
  .mem_rd_en_i (mem_rd_en_o),
  .out_valid_i (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_i  (out_data_o),
  .out_last_i  (out_last_o),
  .event_i     (event_o),
  .stat_pop_i  (stat_pop_i)
);

// File: tb/test_tx_slot_reader.sv
`timescale 1ns/1ps
module test_tx_slot_reader;
  localparam int SB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [0:0]  cmd_slot = '0;
  logic [15:0] cmd_len = '0;
  logic        rd_en;
  logic [6:0]  rd_addr;
  logic [7:0]  rd_data = '0;
  logic        out_valid, out_ready, out_last;
  logic [7:0]  out_data;
  logic [31:0] tick = '0;
  logic        ev, stat_pop = 1'b0;
  logic [0:0]  stat_slot;
  logic [31:0] stat_ts;

  // second instance: timestamp option off
  logic        p_cmd_valid = 1'b0, p_cmd_ready;
  logic [0:0]  p_cmd_slot = '0;
  logic [15:0] p_cmd_len = '0;
  logic        p_rd_en, p_valid, p_last, p_ev;
  logic [6:0]  p_addr;
  logic [7:0]  p_rd_data = '0, p_data;
  logic [0:0]  p_slot;
  logic [31:0] p_ts;

  int checks = 0, fails = 0;
  int ready_mode = 0;
  int ncnt = 0;
  logic [8:0]  exp_q[$];
  int          exp_slot_q[$];
  logic [31:0] ts_q[$];
  bit mon_first = 1'b1;
  bit prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  logic prev_last = 1'b0;
  int p_ev_cnt = 0, p_ev_slot = -1;
  bit p_ev_prev = 1'b0, p_ev_wide = 1'b0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) tick <= tick + 1;
  always @(negedge clk) ncnt <= ncnt + 1;
  assign out_ready = (ready_mode == 0) ? 1'b1 :
                     (ready_mode == 2) ? 1'b0 : ((ncnt % 3) != 1) && ((ncnt % 7) != 4);

  always @(posedge clk) begin
    if (rd_en)   rd_data   <= 8'(rd_addr * 13 + 5);
    if (p_rd_en) p_rd_data <= 8'(p_addr * 13 + 5);
  end

  tx_slot_reader i_tx_slot_reader (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_slot_i(cmd_slot), .cmd_len_i(cmd_len),
    .mem_rd_en_o(rd_en), .mem_addr_o(rd_addr), .mem_rd_data_i(rd_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data), .out_last_o(out_last),
    .ts_i(tick), .event_o(ev), .stat_pop_i(stat_pop), .stat_slot_o(stat_slot), .stat_ts_o(stat_ts)
  );

  tx_slot_reader #(.TS_EN(0)) i_tx_slot_reader_pulse (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(p_cmd_valid), .cmd_ready_o(p_cmd_ready), .cmd_slot_i(p_cmd_slot), .cmd_len_i(p_cmd_len),
    .mem_rd_en_o(p_rd_en), .mem_addr_o(p_addr), .mem_rd_data_i(p_rd_data),
    .out_valid_o(p_valid), .out_ready_i(1'b1), .out_data_o(p_data), .out_last_o(p_last),
    .ts_i(tick), .event_o(p_ev), .stat_pop_i(1'b0), .stat_slot_o(p_slot), .stat_ts_o(p_ts)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prev_stall)
        chk(out_valid && out_data == prev_data && out_last == prev_last, "R4", "stalled byte held",
            {out_valid, out_last, out_data}, {1'b1, prev_last, prev_data});
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected byte", out_data, -1);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk(out_data == e[7:0], "R1", "byte value", out_data, e[7:0]);
          chk(out_last == e[8], "R2", "last marker", out_last, e[8]);
        end
        if (mon_first) ts_q.push_back(tick);
        mon_first = out_last;
      end
      if (p_ev) begin
        p_ev_cnt++;
        p_ev_slot = int'(p_slot);
        if (p_ev_prev) p_ev_wide = 1'b1;
      end
      p_ev_prev = p_ev;
    end
  end

  task automatic send(input int slot, input int len);
    int eff;
    eff = (len == 0 || len > SB) ? SB : len;
    for (int i = 0; i < eff; i++)
      exp_q.push_back({(i == eff - 1), 8'((slot * SB + i) * 13 + 5)});
    exp_slot_q.push_back(slot);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_slot = 1'(slot); cmd_len = 16'(len);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pop_rec();
    for (int i = 0; i < 2000 && !ev; i++) @(negedge clk);
    chk(ev, "R7", "event high with records waiting", ev, 1);
    if (exp_slot_q.size() > 0) begin
      int es;
      es = exp_slot_q.pop_front();
      chk(int'(stat_slot) == es, "R5", "record slot", stat_slot, es);
    end else chk(1'b0, "R5", "extra record", stat_slot, -1);
    if (ts_q.size() > 0) begin
      logic [31:0] et;
      et = ts_q.pop_front();
      chk(stat_ts == et, "R6", "record timestamp", stat_ts, et);
    end else chk(1'b0, "R6", "no first-byte time seen", stat_ts, -1);
    stat_pop = 1'b1;
    @(negedge clk);
    stat_pop = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 5000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!out_valid, "R10", "valid in reset", out_valid, 0);
    chk(!ev, "R10", "event in reset", ev, 0);
    chk(cmd_ready, "R10", "cmd ready in reset", cmd_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // plain frame, ready always high
    send(0, 10);
    drain();
    chk(ev, "R7", "event after one frame", ev, 1);
    pop_rec();
    chk(!ev, "R7", "event low after last pop", ev, 0);

    // backpressure with clamped lengths (R3)
    ready_mode = 1;
    send(1, 20);
    send(0, 0);
    send(1, 100);
    drain();
    chk(exp_q.size() == 0, "R3", "clamped frames fully sent", exp_q.size(), 0);
    pop_rec();
    chk(ev, "R7", "event held with two left", ev, 1);
    pop_rec();
    pop_rec();
    chk(!ev, "R3", "one record per clamped frame", ev, 0);

    // command queue full (R9) and status FIFO full (R11)
    ready_mode = 2;
    for (int k = 0; k < 5; k++) send(k % 2, 3);
    @(negedge clk);
    chk(!cmd_ready, "R9", "ready low with queue full", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_slot = 1'b1; cmd_len = 16'd7;
    @(negedge clk);
    cmd_valid = 1'b0;
    ready_mode = 0;
    repeat (300) @(negedge clk);
    chk(exp_q.size() == 3, "R11", "fifth frame waits for room", exp_q.size(), 3);
    chk(!out_valid, "R11", "no output while status full", out_valid, 0);
    pop_rec();
    drain();
    chk(exp_q.size() == 0, "R11", "fifth frame sent after pop", exp_q.size(), 0);
    for (int k = 0; k < 4; k++) pop_rec();
    repeat (100) @(negedge clk);
    chk(!ev, "R9", "dropped command made no record", ev, 0);
    chk(!out_valid && exp_q.size() == 0, "R9", "dropped command sent nothing", out_valid, 0);

    // pulse build (R8)
    @(negedge clk);
    p_cmd_valid = 1'b1; p_cmd_slot = 1'b1; p_cmd_len = 16'd5;
    @(negedge clk);
    p_cmd_valid = 1'b0;
    repeat (60) @(negedge clk);
    chk(p_ev_cnt == 1, "R8", "one pulse per frame", p_ev_cnt, 1);
    chk(p_ev_slot == 1, "R8", "slot during pulse", p_ev_slot, 1);
    p_cmd_valid = 1'b1; p_cmd_slot = 1'b0; p_cmd_len = 16'd2;
    @(negedge clk);
    p_cmd_valid = 1'b0;
    repeat (60) @(negedge clk);
    chk(p_ev_cnt == 2, "R8", "second pulse", p_ev_cnt, 2);
    chk(p_ev_slot == 0, "R8", "slot during second pulse", p_ev_slot, 0);
    chk(!p_ev_wide, "R8", "pulse width one cycle", p_ev_wide, 0);

    finish_run();
  end
endmodule